// File: doc/BRIEF.md
# Single-Adder Signed Calculator Datapath

This block is a purely combinational arithmetic unit. It accepts two small two's complement operands and a two-bit operation select, and returns a result one bit wider than the operands. The four operations are the sum, the difference, the magnitude of the first operand and the magnitude of the second operand.

All four operations pass through a single ripple-carry adder built from one-bit full-adder cells. A steering stage in front of the adder picks the X and Y words and the carry-in for each operation. It sign-extends each operand by one bit and can invert Y and force X or Y to zero. The result is the adder's sum word. The carry-out plays no part in the result.

The block is meant to be dropped into a larger datapath wherever a small signed add, subtract or magnitude function is needed without a second adder.

Top module: `shared_adder_calc`

## Requirements
- R1: With select code 2'b11 the result equals opa + opb, both read as signed OPW-bit values, given as an (OPW+1)-bit two's complement word.
- R2: With select code 2'b10 the result equals opa - opb, both read as signed values, given as an (OPW+1)-bit two's complement word.
- R3: With select code 2'b01 the result equals the magnitude of signed opb, and opa has no effect on it.
- R4: With select code 2'b00 the result equals the magnitude of signed opa, and opb has no effect on it.
- R5: Results at the ends of the range are exact: 7 - (-8) gives +15 (5'b01111) and -8 + (-8) gives -16 (5'b10000).
- R6: The magnitude of the most negative operand is exact: the magnitude of -8 gives +8 (5'b01000), and both magnitude codes give a result with a clear sign bit.
- R7: The single adder's carry-out and sum together equal X + Y + carry-in for every input pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | OPW (4) | First operand, two's complement |
| opb | input | OPW (4) | Second operand, two's complement |
| opsel | input | 2 | Operation: 11 add, 10 subtract, 01 magnitude of opb, 00 magnitude of opa |
| result | output | OPW+1 (5) | Two's complement result |

## Verification
The bench sweeps every operand pair under every select code and compares the result with signed integer arithmetic. This covers several corner cases:
- The sums and differences that overflow four bits. A design that skipped the sign extension would wrap 7-(-8) to -1 and -16 to 0.
- The magnitude of -8. A design that negated within four bits would return -8.
- The unused operand under each magnitude code. A design with miswired select steering would let the unused operand change the result.
- Positive operands under the magnitude codes. A design that always inverted would corrupt these.

// File: rtl/calc_pkg.sv
package calc_pkg;

   typedef enum logic [1:0] {
      SEL_MAG_A = 2'b00,
      SEL_MAG_B = 2'b01,
      SEL_DIFF  = 2'b10,
      SEL_SUM   = 2'b11
   } calc_sel_e;

   // Steering decision handed from the operand stage to the adder
   typedef struct packed {
      logic invert_y;
      logic carry_in;
   } steer_ctl_t;

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic half;

   always_comb begin
      half = a_i ^ b_i;
      s_o  = half ^ c_i;
      c_o  = (a_i & b_i) | (c_i & half);
   end
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
   parameter int W = 5
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   // chain[k] is the carry entering bit k
   logic [W:0] chain;

   assign chain[0] = cin_i;

   generate
      if (W < 1) begin : g_bad_width
         $error("ripple_adder: W must be at least 1");
      end
      for (genvar k = 0; k < W; k++) begin : g_bit
         fa_cell u_fa (
            .a_i (x_i[k]),
            .b_i (y_i[k]),
            .c_i (chain[k]),
            .s_o (sum_o[k]),
            .c_o (chain[k+1])
         );
      end
   endgenerate

   assign cout_o = chain[W];
endmodule

// File: rtl/operand_steer.sv
module operand_steer
   import calc_pkg::*;
#(
   parameter int OPW = 4,
   localparam int RW = OPW + 1
) (
   input  logic [OPW-1:0] opa_i,
   input  logic [OPW-1:0] opb_i,
   input  logic [1:0]     sel_i,
   output logic [RW-1:0]  x_o,
   output logic [RW-1:0]  y_o,
   output logic           cin_o
);
   logic [RW-1:0] ext_a;
   logic [RW-1:0] ext_b;
   logic [RW-1:0] mag_src;
   logic          mag_neg;
   logic          is_mag;
   steer_ctl_t    ctl;

   // one-bit sign extension keeps every result representable
   assign ext_a = {opa_i[OPW-1], opa_i};
   assign ext_b = {opb_i[OPW-1], opb_i};

   // select bit 1 low means a magnitude code; bit 0 then picks the operand
   assign is_mag  = ~sel_i[1];
   assign mag_src = sel_i[0] ? ext_b : ext_a;
   assign mag_neg = mag_src[RW-1];

   always_comb begin
      ctl.invert_y = 1'b0;
      ctl.carry_in = 1'b0;
      x_o          = ext_a;
      y_o          = ext_b;
      unique case (calc_sel_e'(sel_i))
         SEL_SUM: begin
            x_o = ext_a;
            y_o = ext_b;
         end
         SEL_DIFF: begin
            ctl.invert_y = 1'b1;
            ctl.carry_in = 1'b1;
            x_o          = ext_a;
            y_o          = ~ext_b;
         end
         SEL_MAG_A, SEL_MAG_B: begin
            ctl.invert_y = is_mag & mag_neg;
            ctl.carry_in = is_mag & mag_neg;
            x_o          = mag_neg ? '0 : mag_src;
            y_o          = mag_neg ? ~mag_src : '0;
         end
         default: begin
            x_o = ext_a;
            y_o = ext_b;
         end
      endcase
      cin_o = ctl.carry_in;
   end
endmodule

// File: rtl/shared_adder_calc.sv
module shared_adder_calc #(
   parameter int OPW = 4,
   localparam int RW = OPW + 1
) (
   input  logic [OPW-1:0] opa,
   input  logic [OPW-1:0] opb,
   input  logic [1:0]     opsel,
   output logic [RW-1:0]  result
);
   generate
      if (OPW < 2) begin : g_bad_opw
         $error("shared_adder_calc: OPW must be at least 2");
      end
   endgenerate

   logic [RW-1:0] add_x;
   logic [RW-1:0] add_y;
   logic          add_cin;
   logic [RW-1:0] add_sum;
   logic          add_cout;

   operand_steer #(.OPW(OPW)) u_steer (
      .opa_i (opa),
      .opb_i (opb),
      .sel_i (opsel),
      .x_o   (add_x),
      .y_o   (add_y),
      .cin_o (add_cin)
   );

   ripple_adder #(.W(RW)) u_adder (
      .x_i    (add_x),
      .y_i    (add_y),
      .cin_i  (add_cin),
      .sum_o  (add_sum),
      .cout_o (add_cout)
   );

   assign result = add_sum;
endmodule

// File: rtl/calc_checker.sv
module calc_checker #(
   parameter int OPW = 4,
   localparam int RW = OPW + 1
) (
   input logic [OPW-1:0] opa,
   input logic [OPW-1:0] opb,
   input logic [1:0]     opsel,
   input logic [RW-1:0]  result,
   input logic [RW-1:0]  add_x,
   input logic [RW-1:0]  add_y,
   input logic           add_cin,
   input logic [RW-1:0]  add_sum,
   input logic           add_cout
);
   logic [RW-1:0] wa, wb;
   logic [RW:0]   full;

   always_comb begin
      wa   = {opa[OPW-1], opa};
      wb   = {opb[OPW-1], opb};
      full = {1'b0, add_x} + {1'b0, add_y} + {{RW{1'b0}}, add_cin};
      if (opsel == 2'b11) begin
         // R1
         sum_result_chk: assert (result == wa + wb);
      end
      if (opsel == 2'b10) begin
         // R2
         diff_result_chk: assert (result == wa - wb);
      end
      if (opsel == 2'b01) begin
         // R3
         mag_b_chk: assert (result == (wb[RW-1] ? -wb : wb));
      end
      if (opsel == 2'b00) begin
         // R4
         mag_a_chk: assert (result == (wa[RW-1] ? -wa : wa));
      end
      if (opsel[1] == 1'b0) begin
         // R6
         mag_sign_chk: assert (result[RW-1] == 1'b0);
      end
      // R7
      adder_sum_chk: assert ({add_cout, add_sum} == full);
   end
endmodule

bind shared_adder_calc calc_checker #(.OPW(OPW)) u_calc_chk (
   .opa      (opa),
   .opb      (opb),
   .opsel    (opsel),
   .result   (result),
   .add_x    (add_x),
   .add_y    (add_y),
   .add_cin  (add_cin),
   .add_sum  (add_sum),
   .add_cout (add_cout)
);

// File: tb/sim_shared_adder_calc.sv
`timescale 1ns/1ps
module sim_shared_adder_calc;
   localparam int OPW = 4;
   localparam int RW  = OPW + 1;

   logic           clk = 1'b0;
   logic [OPW-1:0] opa = '0;
   logic [OPW-1:0] opb = '0;
   logic [1:0]     opsel = 2'b00;
   logic [RW-1:0]  result;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   shared_adder_calc #(.OPW(OPW)) u0 (
      .opa    (opa),
      .opb    (opb),
      .opsel  (opsel),
      .result (result)
   );

   function automatic int sval(input logic [OPW-1:0] v);
      return v[OPW-1] ? int'(v) - (1 << OPW) : int'(v);
   endfunction

   function automatic int model(input logic [1:0] s, input int a, input int b);
      case (s)
         2'b11:   return a + b;
         2'b10:   return a - b;
         2'b01:   return (b < 0) ? -b : b;
         default: return (a < 0) ? -a : a;
      endcase
   endfunction

   // drive after a rising edge, sample at the following falling edge
   task automatic apply_check(input logic [1:0] s, input logic [OPW-1:0] a,
                              input logic [OPW-1:0] b, input int expv, input string req);
      int got;
      @(posedge clk);
      opsel = s; opa = a; opb = b;
      @(negedge clk);
      got = int'($signed(result));
      checks++;
      if (got != expv) begin
         errors++;
         $display("FAIL %s sel=%b a=%0d b=%0d actual=%0d expected=%0d",
                  req, s, sval(a), sval(b), got, expv);
      end
   endtask

   initial begin
      #(20.0 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // reset state: all inputs zero, magnitude of zero (R4)
      apply_check(2'b00, 4'h0, 4'h0, 0, "R4");

      // named range-end cases (R5) and most-negative magnitude (R6)
      apply_check(2'b10, 4'h7, 4'h8, 15,  "R5");
      apply_check(2'b11, 4'h8, 4'h8, -16, "R5");
      apply_check(2'b11, 4'h1, 4'h9, -6,  "R1");
      apply_check(2'b10, 4'h0, 4'h7, -7,  "R2");
      apply_check(2'b11, 4'hF, 4'h1, 0,   "R1");
      apply_check(2'b00, 4'h7, 4'h3, 7,   "R4");
      apply_check(2'b00, 4'h8, 4'h2, 8,   "R6");
      apply_check(2'b01, 4'h5, 4'h8, 8,   "R6");

      // exhaustive sweep; R7 is exercised by every pattern through the result
      for (int s = 3; s >= 0; s--) begin
         for (int a = 0; a < (1 << OPW); a++) begin
            for (int b = 0; b < (1 << OPW); b++) begin
               string tag;
               case (s)
                  3: tag = "R1";
                  2: tag = "R2";
                  1: tag = "R3";
                  default: tag = "R4";
               endcase
               apply_check(s[1:0], a[OPW-1:0], b[OPW-1:0],
                           model(s[1:0], sval(a[OPW-1:0]), sval(b[OPW-1:0])), tag);
            end
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule